// File: doc/BRIEF.md
# Hardware Thread Barrier Unit

The unit holds hardware threads at numbered synchronization points. A thread that reaches a barrier instruction sends one arrival to the unit. The arrival carries the thread's index, a barrier number chosen by software (the first source operand), and the number of threads that must meet there (the second source operand). The unit keeps up to `NUM_SLOTS` barriers open at once. The first arrival with a number that is not open yet claims the lowest free slot. Later arrivals with the same number join that slot. Every thread that has joined is blocked until the slot is released.

A slot is released when its arrival count equals the expected count and the memory-pending input is low. That input stands for the outstanding data transfers that must finish before any thread may go past the barrier. On release the unit clears the wait bits of all members in one cycle, pulses `rel_valid`, and frees the slot. Some arrivals are malformed or cannot be placed in a slot. These are refused with an error code, and the thread that sent them is not blocked.

Arrivals use a valid/ready handshake. An arrival is taken on a rising edge where `arr_valid` and `arr_ready` are both high, and the unit takes at most one per cycle. `arr_ready` is low during reset and goes high on the first clock edge after reset is released. It then stays high, so the unit never applies back-pressure. The requester may change the arrival fields freely while `arr_valid` is low. The release outputs and the error outputs are plain one-cycle pulses with no handshake.

Top module: `thread_barrier_unit`

## Requirements
- R1: During reset and after it, `wait_mask`, `rel_valid` and `err_valid` are 0 and every thread_state field reads 1. `arr_ready` is 0 in reset and becomes 1 on the first clock edge after reset is released.
- R2: An accepted arrival sets bit t of `wait_mask`, and sets the field `thread_state[3t+2:3t]` to 4 (waiting), in the cycle after the accepting edge. Threads that are not waiting read 1 (running) in their field.
- R3: Suppose that after an accepting edge a slot's arrival count equals its expected count and `mem_busy` is low. Then at the next edge `rel_valid` pulses for one cycle, with `rel_id` set to the barrier number and `rel_threads` set to the member threads. Those wait bits clear in that same cycle. An expected count of 1 therefore releases one cycle after it arrives.
- R4: No release happens on an edge where `mem_busy` is sampled high. A complete slot is released on the first edge at which `mem_busy` is low.
- R5: Up to `NUM_SLOTS` barriers with distinct nonzero numbers can be open at the same time, and each counts only its own arrivals.
- R6: An arrival is refused, with `err_valid` high and `err_code`=1 in the next cycle and no change to any wait bit or slot, in any of these cases:
  - the barrier number is 0;
  - the expected count is 0 or greater than `NUM_THREADS`;
  - the sending thread is already waiting.
- R7: An arrival with a barrier number that is not open, when every slot is in use, is refused with `err_code`=2, and the thread is not blocked.
- R8: An arrival to an open barrier is refused with `err_code`=3, and the thread is not blocked, in either of these cases:
  - its expected count differs from the one recorded for that barrier;
  - that barrier already has all its arrivals.
- R9: A new barrier takes the lowest-numbered free slot. When several slots are complete together, they are released one per cycle, lowest slot index first.
- R10: An arrival sees the slot state from before the edge that accepts it. A slot being released on that same edge is still busy to this arrival. The slot can be claimed from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| arr_valid | input | 1 | Arrival request present |
| arr_ready | output | 1 | Unit takes arrivals |
| arr_thread | input | clog2(NUM_THREADS) | Index of the arriving thread |
| arr_id | input | ID_W | Barrier number, must be nonzero |
| arr_count | input | clog2(NUM_THREADS+1) | Threads expected at this barrier |
| mem_busy | input | 1 | Outstanding data transfers; holds back release |
| wait_mask | output | NUM_THREADS | One bit per blocked thread |
| thread_state | output | 3*NUM_THREADS | Per-thread status code: 4 waiting, 1 running |
| rel_valid | output | 1 | One-cycle release pulse |
| rel_id | output | ID_W | Barrier number being released |
| rel_threads | output | NUM_THREADS | Threads freed by this release |
| err_valid | output | 1 | One-cycle refusal pulse |
| err_code | output | 2 | 1 bad argument, 2 no free slot, 3 count conflict |

## Verification
A release of one slot can fall in the same cycle as the acceptance of a new arrival. The bench provokes this by filling every slot while `mem_busy` holds one complete slot back. It then lowers `mem_busy` on the same clock edge at which an arrival with a new number is accepted. The result is judged on the next cycle: `rel_valid` and `err_valid` must both be high, with `err_code`=2, because the arrival still saw the slot as busy. A repeat of that arrival must then claim the freed slot and release on its own. Two complete slots that are held back together are also released, and each release is checked for its order and its member mask.

// File: rtl/barrier_pkg.sv
package barrier_pkg;
  typedef enum logic [1:0] {
    BERR_NONE     = 2'd0,
    BERR_ARG      = 2'd1,
    BERR_FULL     = 2'd2,
    BERR_CONFLICT = 2'd3
  } bar_err_e;

  localparam logic [2:0] TSTATE_RUN  = 3'd1;
  localparam logic [2:0] TSTATE_WAIT = 3'd4;
endpackage

// File: rtl/bar_prio_enc.sv
// Lowest-index-first encoder over a request vector.
module bar_prio_enc #(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/bar_slot_match.sv
// Compares the incoming barrier number against every open slot.
module bar_slot_match #(
  parameter int NS   = 4,
  parameter int ID_W = 8
) (
  input  logic [NS-1:0]           vld,
  input  logic [NS-1:0][ID_W-1:0] ids,
  input  logic [ID_W-1:0]         key,
  output logic [NS-1:0]           hit
);
  for (genvar s = 0; s < NS; s++) begin : g_cmp
    assign hit[s] = vld[s] && (ids[s] == key);
  end
endmodule

// File: rtl/bar_slot_entry.sv
// State of one barrier slot: number, expected count, arrivals, members.
module bar_slot_entry #(
  parameter int NT    = 8,
  parameter int ID_W  = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             alloc,
  input  logic             join_en,
  input  logic [NT-1:0]    who,
  input  logic [ID_W-1:0]  new_id,
  input  logic [CNT_W-1:0] new_exp,
  output logic             vld,
  output logic [ID_W-1:0]  id,
  output logic [CNT_W-1:0] exp_cnt,
  output logic [CNT_W-1:0] arr_cnt,
  output logic [NT-1:0]    members,
  output logic             done
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld     <= 1'b0;
      id      <= '0;
      exp_cnt <= '0;
      arr_cnt <= '0;
      members <= '0;
    end else if (clr) begin
      vld     <= 1'b0;
      arr_cnt <= '0;
      members <= '0;
    end else if (alloc) begin
      vld     <= 1'b1;
      id      <= new_id;
      exp_cnt <= new_exp;
      arr_cnt <= CNT_W'(1);
      members <= who;
    end else if (join_en) begin
      arr_cnt <= arr_cnt + CNT_W'(1);
      members <= members | who;
    end
  end

  assign done = vld && (arr_cnt == exp_cnt);
endmodule

// File: rtl/bar_wait_view.sv
// Folds slot membership into per-thread wait bits and status codes.
module bar_wait_view #(
  parameter int NS = 4,
  parameter int NT = 8
) (
  input  logic [NS-1:0][NT-1:0] members,
  output logic [NT-1:0]         wait_mask,
  output logic [3*NT-1:0]       thread_state
);
  import barrier_pkg::*;

  for (genvar t = 0; t < NT; t++) begin : g_thr
    logic [NS-1:0] in_slot;
    for (genvar s = 0; s < NS; s++) begin : g_slot
      assign in_slot[s] = members[s][t];
    end
    assign wait_mask[t]          = |in_slot;
    assign thread_state[3*t +: 3] = (|in_slot) ? TSTATE_WAIT : TSTATE_RUN;
  end
endmodule

// File: rtl/thread_barrier_unit.sv
module thread_barrier_unit #(
  parameter int NUM_THREADS = 8,
  parameter int NUM_SLOTS   = 4,
  parameter int ID_W        = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             arr_valid,
  output logic                             arr_ready,
  input  logic [$clog2(NUM_THREADS)-1:0]   arr_thread,
  input  logic [ID_W-1:0]                  arr_id,
  input  logic [$clog2(NUM_THREADS+1)-1:0] arr_count,
  input  logic                             mem_busy,
  output logic [NUM_THREADS-1:0]           wait_mask,
  output logic [3*NUM_THREADS-1:0]         thread_state,
  output logic                             rel_valid,
  output logic [ID_W-1:0]                  rel_id,
  output logic [NUM_THREADS-1:0]           rel_threads,
  output logic                             err_valid,
  output logic [1:0]                       err_code
);
  import barrier_pkg::*;

  localparam int NT    = NUM_THREADS;
  localparam int NS    = NUM_SLOTS;
  localparam int CNT_W = $clog2(NUM_THREADS + 1);
  localparam int SIW   = (NS > 1) ? $clog2(NS) : 1;

  // slot state gathered from the entries
  logic [NS-1:0]            s_vld;
  logic [NS-1:0]            s_done;
  logic [NS-1:0][ID_W-1:0]  s_id;
  logic [NS-1:0][CNT_W-1:0] s_exp;
  logic [NS-1:0][CNT_W-1:0] s_cnt;
  logic [NS-1:0][NT-1:0]    s_mem;

  logic           ready_q;
  logic           accept;
  logic [NT-1:0]  who;
  logic [NS-1:0]  hit_vec;
  logic           hit_any, free_any, rel_any, rel_fire;
  logic [SIW-1:0] hit_idx, free_idx, rel_idx;
  logic           bad_arg, conflict;
  logic           do_join, do_alloc;
  bar_err_e       err_n;

  always_ff @(posedge clk) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end
  assign arr_ready = ready_q;
  assign accept    = arr_valid && ready_q;
  assign who       = NT'(1) << arr_thread;

  bar_slot_match #(.NS(NS), .ID_W(ID_W)) u_match (
    .vld (s_vld),
    .ids (s_id),
    .key (arr_id),
    .hit (hit_vec)
  );

  bar_prio_enc #(.N(NS), .IW(SIW)) u_hit_enc (
    .req (hit_vec), .any (hit_any), .idx (hit_idx)
  );

  bar_prio_enc #(.N(NS), .IW(SIW)) u_free_enc (
    .req (~s_vld), .any (free_any), .idx (free_idx)
  );

  bar_prio_enc #(.N(NS), .IW(SIW)) u_rel_enc (
    .req (s_done), .any (rel_any), .idx (rel_idx)
  );

  // arrival classification
  always_comb begin
    bad_arg  = (arr_id == '0) || (arr_count == '0) ||
               (int'(arr_count) > NT) || wait_mask[arr_thread];
    conflict = hit_any && ((s_exp[hit_idx] != arr_count) || s_done[hit_idx]);
    err_n    = BERR_NONE;
    do_join  = 1'b0;
    do_alloc = 1'b0;
    if (accept) begin
      if (bad_arg)        err_n    = BERR_ARG;
      else if (hit_any) begin
        if (conflict)     err_n    = BERR_CONFLICT;
        else              do_join  = 1'b1;
      end
      else if (free_any)  do_alloc = 1'b1;
      else                err_n    = BERR_FULL;
    end
  end

  assign rel_fire = rel_any && !mem_busy;

  for (genvar s = 0; s < NS; s++) begin : g_slot
    bar_slot_entry #(.NT(NT), .ID_W(ID_W), .CNT_W(CNT_W)) u_entry (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (rel_fire && (rel_idx == SIW'(s))),
      .alloc   (do_alloc && (free_idx == SIW'(s))),
      .join_en (do_join && (hit_idx == SIW'(s))),
      .who     (who),
      .new_id  (arr_id),
      .new_exp (arr_count),
      .vld     (s_vld[s]),
      .id      (s_id[s]),
      .exp_cnt (s_exp[s]),
      .arr_cnt (s_cnt[s]),
      .members (s_mem[s]),
      .done    (s_done[s])
    );
  end

  bar_wait_view #(.NS(NS), .NT(NT)) u_view (
    .members      (s_mem),
    .wait_mask    (wait_mask),
    .thread_state (thread_state)
  );

  // registered pulses
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rel_valid   <= 1'b0;
      rel_id      <= '0;
      rel_threads <= '0;
      err_valid   <= 1'b0;
      err_code    <= 2'd0;
    end else begin
      rel_valid   <= rel_fire;
      rel_id      <= rel_fire ? s_id[rel_idx]  : '0;
      rel_threads <= rel_fire ? s_mem[rel_idx] : '0;
      err_valid   <= (err_n != BERR_NONE);
      err_code    <= err_n;
    end
  end
endmodule

// File: rtl/thread_barrier_checker.sv
module thread_barrier_checker #(
  parameter int NUM_THREADS = 8,
  parameter int ID_W        = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   arr_ready,
  input logic                   mem_busy,
  input logic [NUM_THREADS-1:0] wait_mask,
  input logic                   rel_valid,
  input logic [ID_W-1:0]        rel_id,
  input logic [NUM_THREADS-1:0] rel_threads,
  input logic                   err_valid,
  input logic [1:0]             err_code
);
  AST_REL_CLEARS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid |-> ((rel_threads & wait_mask) == '0)); // R3

  AST_REL_FROM_WAITERS: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid |-> ((rel_threads & ~$past(wait_mask)) == '0)); // R3

  AST_REL_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid |-> (rel_id != '0) && (rel_threads != '0)); // R5

  AST_NO_REL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid |-> !$past(mem_busy)); // R4

  AST_ERR_NO_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> ((wait_mask & ~$past(wait_mask)) == '0)); // R6

  AST_ERR_CODED: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> (err_code != 2'd0)); // R7

  AST_READY_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(arr_ready) |-> arr_ready); // R1
endmodule

bind thread_barrier_unit thread_barrier_checker #(
  .NUM_THREADS (NUM_THREADS),
  .ID_W        (ID_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .arr_ready   (arr_ready),
  .mem_busy    (mem_busy),
  .wait_mask   (wait_mask),
  .rel_valid   (rel_valid),
  .rel_id      (rel_id),
  .rel_threads (rel_threads),
  .err_valid   (err_valid),
  .err_code    (err_code)
);

// File: tb/test_thread_barrier_unit.sv
module test_thread_barrier_unit;
  localparam int NT = 4;
  localparam int NS = 2;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          arr_valid = 1'b0;
  logic          arr_ready;
  logic [1:0]    arr_thread = '0;
  logic [IW-1:0] arr_id = '0;
  logic [2:0]    arr_count = '0;
  logic          mem_busy = 1'b0;
  logic [NT-1:0] wait_mask;
  logic [3*NT-1:0] thread_state;
  logic          rel_valid;
  logic [IW-1:0] rel_id;
  logic [NT-1:0] rel_threads;
  logic          err_valid;
  logic [1:0]    err_code;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  thread_barrier_unit #(.NUM_THREADS(NT), .NUM_SLOTS(NS), .ID_W(IW)) i_thread_barrier_unit (
    .clk (clk), .rst_n (rst_n), .arr_valid (arr_valid), .arr_ready (arr_ready),
    .arr_thread (arr_thread), .arr_id (arr_id), .arr_count (arr_count),
    .mem_busy (mem_busy), .wait_mask (wait_mask), .thread_state (thread_state),
    .rel_valid (rel_valid), .rel_id (rel_id), .rel_threads (rel_threads),
    .err_valid (err_valid), .err_code (err_code)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int expv);
    check(act == expv, req, act, expv);
  endtask

  // start and end at a falling edge
  task automatic arrive(input int t, input int id, input int c);
    arr_valid  = 1'b1;
    arr_thread = 2'(t);
    arr_id     = IW'(id);
    arr_count  = 3'(c);
    @(negedge clk);
    arr_valid  = 1'b0;
  endtask

  task automatic expect_err(input string req, input int code, input int mask);
    chk_eq({req, " err_valid"}, int'(err_valid), 1);
    chk_eq({req, " err_code"}, int'(err_code), code);
    chk_eq({req, " wait_mask"}, int'(wait_mask), mask);
  endtask

  task automatic expect_rel(input string req, input int id, input int mask, input int left);
    chk_eq({req, " rel_valid"}, int'(rel_valid), 1);
    chk_eq({req, " rel_id"}, int'(rel_id), id);
    chk_eq({req, " rel_threads"}, int'(rel_threads), mask);
    chk_eq({req, " wait_mask after release"}, int'(wait_mask), left);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk_eq("R1 ready in reset", int'(arr_ready), 0);
    chk_eq("R1 wait_mask", int'(wait_mask), 0);
    chk_eq("R1 rel_valid", int'(rel_valid), 0);
    chk_eq("R1 err_valid", int'(err_valid), 0);
    for (int t = 0; t < NT; t++) chk_eq("R1 thread_state", int'(thread_state[3*t +: 3]), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk_eq("R1 ready after reset", int'(arr_ready), 1);

    // R2 R3: sweep expected count 1..NT, threads 0..c-1 on barrier c
    for (int c = 1; c <= NT; c++) begin
      for (int t = 0; t < c; t++) begin
        arrive(t, c, c);
        chk_eq("R2 wait_mask", int'(wait_mask), (1 << (t + 1)) - 1);
        chk_eq("R2 thread_state waiting", int'(thread_state[3*t +: 3]), 4);
        if (t + 1 < NT) chk_eq("R2 idle thread state", int'(thread_state[3*(t+1) +: 3]), 1);
        chk_eq("R3 no early release", int'(rel_valid), 0);
      end
      @(negedge clk);
      expect_rel("R3", c, (1 << c) - 1, 0);
      for (int t = 0; t < NT; t++) chk_eq("R3 state after release", int'(thread_state[3*t +: 3]), 1);
      @(negedge clk);
      chk_eq("R3 pulse one cycle", int'(rel_valid), 0);
    end

    // R4: memory busy holds the release back
    mem_busy = 1'b1;
    arrive(1, 7, 2);
    arrive(3, 7, 2);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk_eq("R4 held rel_valid", int'(rel_valid), 0);
      chk_eq("R4 held wait_mask", int'(wait_mask), 'b1010);
    end
    mem_busy = 1'b0;
    @(negedge clk);
    expect_rel("R4", 7, 'b1010, 0);

    // R6: bad arguments
    for (int c = 0; c <= 7; c++) begin
      arrive(0, 0, c);
      expect_err("R6 id zero", 1, 0);
    end
    arrive(2, 3, 0);
    expect_err("R6 count zero", 1, 0);
    for (int c = NT + 1; c <= 7; c++) begin
      arrive(2, 3, c);
      expect_err("R6 count too big", 1, 0);
    end
    arrive(0, 2, 2);
    chk_eq("R6 setup", int'(err_valid), 0);
    arrive(0, 2, 2);
    expect_err("R6 already waiting", 1, 'b0001);
    arrive(1, 2, 2);
    @(negedge clk);
    expect_rel("R6 count unchanged by refusal", 2, 'b0011, 0);

    // R5 R7 R8: two open barriers, full, conflict
    arrive(0, 5, 2);
    arrive(1, 6, 2);
    chk_eq("R5 two open", int'(wait_mask), 'b0011);
    arrive(2, 9, 1);
    expect_err("R7 no free slot", 2, 'b0011);
    arrive(2, 5, 3);
    expect_err("R8 count differs", 3, 'b0011);
    arrive(3, 6, 2);
    @(negedge clk);
    expect_rel("R5 barrier 6", 6, 'b1010, 'b0001);
    arrive(2, 5, 2);
    @(negedge clk);
    expect_rel("R5 barrier 5", 5, 'b0101, 0);

    // R8: arrival to a complete slot
    mem_busy = 1'b1;
    arrive(0, 4, 2);
    arrive(1, 4, 2);
    arrive(2, 4, 2);
    expect_err("R8 slot already complete", 3, 'b0011);
    mem_busy = 1'b0;
    @(negedge clk);
    expect_rel("R8", 4, 'b0011, 0);

    // R9: two complete slots, lowest slot first
    mem_busy = 1'b1;
    arrive(0, 1, 1);
    arrive(1, 2, 1);
    chk_eq("R9 both held", int'(wait_mask), 'b0011);
    mem_busy = 1'b0;
    @(negedge clk);
    expect_rel("R9 first", 1, 'b0001, 'b0010);
    @(negedge clk);
    expect_rel("R9 second", 2, 'b0010, 0);
    @(negedge clk);

    // R10: release and new arrival on the same edge
    mem_busy = 1'b1;
    arrive(0, 3, 1);
    arrive(1, 8, 2);
    mem_busy = 1'b0;
    arrive(2, 11, 1);
    chk_eq("R10 release same cycle", int'(rel_valid), 1);
    chk_eq("R10 release id", int'(rel_id), 3);
    expect_err("R10 slot still busy", 2, 'b0010);
    arrive(2, 11, 1);
    chk_eq("R10 reuse accepted", int'(err_valid), 0);
    chk_eq("R10 reuse waits", int'(wait_mask), 'b0110);
    @(negedge clk);
    expect_rel("R10 reused slot", 11, 'b0100, 'b0010);
    arrive(3, 8, 2);
    @(negedge clk);
    expect_rel("R10 other slot", 8, 'b1010, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule